// File: doc/BRIEF.md
# Runtime-Loadable Byte Substitution Table

This block is an 8-bit in, 8-bit out substitution table whose contents are storage, not fixed logic. The storage is 2048 bits: eight output columns, each made of eight 32-bit cells. Each cell holds one 5-input subfunction of the low input bits, and the three high input bits pick one of a column's eight cells. All 64 cells form a single 1-bit shift chain. The byte lookup is combinational from the stored bits.

Out of reset the table holds a preset bijective mapping, set by two parameters. At run time a loader rewrites the whole table by holding the shift enable high for 2048 clock cycles and presenting one bit per cycle on the serial input. While that happens the previous contents leave the chain, one bit per shift, on the chain output. Lookups are meaningful only while no shift is in progress.

Top module: `rt_sbox`

## Requirements
- R1: When reset is released and before any shift, `sub_out` equals (`lookup_in` × PERM_MUL + PERM_ADD) mod 256. With the default odd multiplier (167, offset 29) this is a bijection on bytes.
- R2: The chain image has positions 0 (head) to 2047 (tail). Output bit k of lookup x is image bit k·256 + x. The low five bits of x pick the entry within a 32-bit cell, and the top three bits pick one of the column's eight cells.
- R3: On each rising edge with `shift_en` high, every image bit moves from position p to p+1, `serial_in` enters at position 0, and the bit at position 2047 is discarded.
- R4: `chain_out` always shows image position 2047. A reload therefore emits the old contents highest position first, one bit per shift.
- R5: A reload of 2048 shifts replaces the whole mapping. The loader sends image position 2047 first and position 0 last. In 128-bit word form, word w (0..15) holds positions 128w..128w+127, which are column w/2 and cells 4·(w mod 2) to 4·(w mod 2)+3. The words go out from the last to the first, most significant bit first.
- R6: While `shift_en` is low, `serial_in` is ignored. Both the mapping and `chain_out` keep their values.
- R7: The lookup has no latency. A new `lookup_in` gives its substituted byte in the same cycle.
- R8: A partial shift of 32 bits moves each cell's contents into the next cell along the chain. The first cell fills with the shifted-in bits.
- R9: Holding `rst_n` low at a clock edge restores the preset mapping of R1. This holds even in the middle of a reload with `shift_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; shifting happens on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset; reloads the preset mapping |
| shift_en | input | 1 | High moves the chain by one bit per cycle |
| serial_in | input | 1 | Load bit entering chain position 0 |
| lookup_in | input | 8 | Byte to substitute |
| sub_out | output | 8 | Substituted byte |
| chain_out | output | 1 | Bit at chain position 2047 |

## Verification
The assertions check four things on every cycle. While nothing has been shifted since reset, the output follows the preset formula. On each shift, every column's head takes its chain input and every column's tail takes the bit just before it. When no shift occurs, the tails and the lookup result stay put. The bench scenarios are needed for the behaviour that spans many cycles. These cover the full 2048-cycle reload with the old image emerging in order, the new mapping afterwards, the cell-to-cell move of a 32-bit partial shift, and a reset arriving in the middle of a load.

// File: rtl/sbox_pkg.sv
package sbox_pkg;

  // Preset affine byte permutation: (x * mul + add) mod 2^width.
  function automatic int unsigned perm_val(int unsigned x, int unsigned mul,
                                           int unsigned add, int unsigned width);
    return (x * mul + add) & ((32'd1 << width) - 32'd1);
  endfunction

  // Chain image position of output bit col for lookup address x.
  function automatic int unsigned image_pos(int unsigned col, int unsigned x,
                                            int unsigned addr_w);
    return (col << addr_w) + x;
  endfunction

endpackage

// File: rtl/sbox_selector.sv
module sbox_selector #(
  parameter int ADDR_W = 8,
  parameter int LO_W   = 5
) (
  input  logic [(1<<ADDR_W)-1:0] table_bits,
  input  logic [ADDR_W-1:0]      addr,
  output logic                   q
);
  localparam int HI_W      = ADDR_W - LO_W;
  localparam int SUBS      = 1 << HI_W;
  localparam int CELL_BITS = 1 << LO_W;

  logic [SUBS-1:0] cell_q;

  // First level: each cell answers the low address bits.
  for (genvar s = 0; s < SUBS; s++) begin : g_cell
    logic [CELL_BITS-1:0] seg;
    assign seg       = table_bits[s*CELL_BITS +: CELL_BITS];
    assign cell_q[s] = seg[addr[LO_W-1:0]];
  end

  // Second level: high address bits choose the cell.
  assign q = cell_q[addr[ADDR_W-1:LO_W]];

endmodule

// File: rtl/sbox_column.sv
module sbox_column
  import sbox_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int LO_W     = 5,
  parameter int COL_IDX  = 0,
  parameter int PERM_MUL = 167,
  parameter int PERM_ADD = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              chain_in,
  input  logic [ADDR_W-1:0] addr,
  output logic              q,
  output logic              head,
  output logic              pre_tail,
  output logic              tail
);
  localparam int COL_BITS = 1 << ADDR_W;

  function automatic logic [COL_BITS-1:0] preset_column();
    logic [COL_BITS-1:0] r;
    for (int x = 0; x < COL_BITS; x++) begin
      r[x] = 1'(perm_val(x, PERM_MUL, PERM_ADD, ADDR_W) >> COL_IDX);
    end
    return r;
  endfunction

  localparam logic [COL_BITS-1:0] PRESET = preset_column();

  logic [COL_BITS-1:0] store;

  always_ff @(posedge clk) begin
    if (!rst_n)        store <= PRESET;
    else if (shift_en) store <= {store[COL_BITS-2:0], chain_in};
  end

  assign head     = store[0];
  assign pre_tail = store[COL_BITS-2];
  assign tail     = store[COL_BITS-1];

  sbox_selector #(.ADDR_W(ADDR_W), .LO_W(LO_W)) u_sel (
    .table_bits(store),
    .addr      (addr),
    .q         (q)
  );

endmodule

// File: rtl/rt_sbox.sv
module rt_sbox #(
  parameter int ADDR_W   = 8,
  parameter int OUT_W    = 8,
  parameter int LO_W     = 5,
  parameter int PERM_MUL = 167,
  parameter int PERM_ADD = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              serial_in,
  input  logic [ADDR_W-1:0] lookup_in,
  output logic [OUT_W-1:0]  sub_out,
  output logic              chain_out
);
  // Named per-column chain taps, brought out for the checker.
  logic [OUT_W-1:0] col_in;
  logic [OUT_W-1:0] col_head;
  logic [OUT_W-1:0] col_pre;
  logic [OUT_W-1:0] col_tail;

  for (genvar k = 0; k < OUT_W; k++) begin : g_col
    if (k == 0) begin : g_first
      assign col_in[k] = serial_in;
    end else begin : g_next
      assign col_in[k] = col_tail[k-1];
    end

    sbox_column #(
      .ADDR_W(ADDR_W), .LO_W(LO_W), .COL_IDX(k),
      .PERM_MUL(PERM_MUL), .PERM_ADD(PERM_ADD)
    ) u_col (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_en(shift_en),
      .chain_in(col_in[k]),
      .addr    (lookup_in),
      .q       (sub_out[k]),
      .head    (col_head[k]),
      .pre_tail(col_pre[k]),
      .tail    (col_tail[k])
    );
  end

  assign chain_out = col_tail[OUT_W-1];

endmodule

// File: rtl/sbox_checker.sv
module sbox_checker
  import sbox_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int OUT_W    = 8,
  parameter int PERM_MUL = 167,
  parameter int PERM_ADD = 29
) (
  input logic              clk,
  input logic              rst_n,
  input logic              shift_en,
  input logic [ADDR_W-1:0] lookup_in,
  input logic [OUT_W-1:0]  sub_out,
  input logic [OUT_W-1:0]  col_in,
  input logic [OUT_W-1:0]  col_head,
  input logic [OUT_W-1:0]  col_pre,
  input logic [OUT_W-1:0]  col_tail
);
  logic             fresh;
  logic [OUT_W-1:0] preset_val;

  always_ff @(posedge clk) begin
    if (!rst_n)        fresh <= 1'b1;
    else if (shift_en) fresh <= 1'b0;
  end

  always_comb preset_val = OUT_W'(perm_val(32'(lookup_in), PERM_MUL, PERM_ADD, ADDR_W));

  a_r1_preset_map: assert property (@(posedge clk) disable iff (!rst_n)
    fresh |-> sub_out == preset_val);

  a_r3_head_entry: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> col_head == $past(col_in));

  a_r4_tail_advance: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> col_tail == $past(col_pre));

  a_r6_idle_tail: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(col_tail));

  a_r6_idle_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> (sub_out == $past(sub_out)) || (lookup_in != $past(lookup_in)));

endmodule

bind rt_sbox sbox_checker #(
  .ADDR_W(ADDR_W), .OUT_W(OUT_W), .PERM_MUL(PERM_MUL), .PERM_ADD(PERM_ADD)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .shift_en (shift_en),
  .lookup_in(lookup_in),
  .sub_out  (sub_out),
  .col_in   (col_in),
  .col_head (col_head),
  .col_pre  (col_pre),
  .col_tail (col_tail)
);

// File: tb/tb_rt_sbox.sv
`timescale 1ns/1ps
module tb_rt_sbox;
  localparam int IMG = 2048;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       shift_en = 1'b0;
  logic       serial_in = 1'b0;
  logic [7:0] lookup_in = 8'd0;
  logic [7:0] sub_out;
  logic       chain_out;

  int n_run = 0;
  int n_fail = 0;
  logic [IMG-1:0] img;   // bench shadow image, position 0 = head

  rt_sbox dut (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .serial_in(serial_in),
    .lookup_in(lookup_in), .sub_out(sub_out), .chain_out(chain_out)
  );

  always #2.5 clk = ~clk;

  // Stimulus / expected pairs for the preset mapping (x*167+29 mod 256).
  localparam logic [15:0] VEC [8] = '{
    {8'd0, 8'd29}, {8'd1, 8'd196}, {8'd2, 8'd107}, {8'd31, 8'd86},
    {8'd32, 8'd253}, {8'd127, 8'd246}, {8'd128, 8'd157}, {8'd255, 8'd118}
  };

  function automatic logic [7:0] preset_f(int x);
    return 8'((x * 167 + 29) % 256);
  endfunction

  function automatic logic [7:0] target_f(logic [7:0] x);
    return {x[3:0], x[7:4]} ^ 8'hC3;
  endfunction

  function automatic logic [IMG-1:0] image_of(bit use_target);
    logic [IMG-1:0] r;
    for (int x = 0; x < 256; x++) begin
      logic [7:0] v;
      v = use_target ? target_f(8'(x)) : preset_f(x);
      for (int k = 0; k < 8; k++) r[k*256 + x] = v[k];
    end
    return r;
  endfunction

  function automatic logic [7:0] model_lookup(logic [7:0] x);
    logic [7:0] v;
    for (int k = 0; k < 8; k++) v[k] = img[k*256 + int'(x)];
    return v;
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic check_all_model(input string tag);
    for (int x = 0; x < 256; x++) begin
      lookup_in = 8'(x);
      #0.01;
      check(tag, sub_out, model_lookup(8'(x)));
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; shift_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    img = image_of(1'b0);
  endtask

  task automatic shift_bit(input logic b, input bit chk_tail, input string tag);
    @(negedge clk);
    if (chk_tail) check(tag, {7'd0, chain_out}, {7'd0, img[IMG-1]});
    shift_en = 1'b1; serial_in = b;
    @(posedge clk);
    img = {img[IMG-2:0], b};
  endtask

  task automatic end_shift();
    @(negedge clk);
    shift_en = 1'b0;
  endtask

  initial begin : wd
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [IMG-1:0] tgt;
    logic [255:0]   seen;
    logic           tail0;
    do_reset();

    // R1: vector table walk over the preset mapping (R7: same-cycle result)
    for (int i = 0; i < 8; i++) begin
      lookup_in = VEC[i][15:8];
      #0.01;
      check("R1 preset vector / R7", sub_out, VEC[i][7:0]);
    end
    // R1: bijection
    seen = '0;
    for (int x = 0; x < 256; x++) begin
      lookup_in = 8'(x); #0.01;
      seen[sub_out] = 1'b1;
    end
    check("R1 bijection count", 8'($countones(seen) - 1), 8'd255);
    // R2: full table against image layout
    check_all_model("R2 layout");

    // R6: serial_in toggling with shift_en low
    tail0 = chain_out;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); serial_in = ~serial_in;
    end
    @(negedge clk);
    check("R6 chain_out idle", {7'd0, chain_out}, {7'd0, tail0});
    check_all_model("R6 mapping idle");

    // R4/R5: full reload, old image emerges from tail
    tgt = image_of(1'b1);
    for (int t = 0; t < IMG; t++) shift_bit(tgt[IMG-1-t], 1'b1, "R4 old bit out");
    end_shift();
    for (int x = 0; x < 256; x++) begin
      lookup_in = 8'(x); #0.01;
      check("R5 reloaded mapping", sub_out, target_f(8'(x)));
    end

    // R8: partial shift of 32 zeros moves cells along
    for (int t = 0; t < 32; t++) shift_bit(1'b0, 1'b1, "R4 partial tail");
    end_shift();
    check_all_model("R8 cell move");

    // R3: single shift of a one
    shift_bit(1'b1, 1'b0, "");
    end_shift();
    check_all_model("R3 single shift");

    // R9: reset in the middle of a reload with shift_en high
    for (int t = 0; t < 100; t++) shift_bit(1'(t % 3 == 0), 1'b0, "");
    @(negedge clk);
    rst_n = 1'b0; shift_en = 1'b1; serial_in = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1; shift_en = 1'b0;
    for (int x = 0; x < 256; x++) begin
      lookup_in = 8'(x); #0.01;
      check("R9 preset after mid-load reset", sub_out, preset_f(x));
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule